// File: doc/BRIEF.md
# Fractional-N Division Ratio Accumulator

This block picks the division ratio that a multi-modulus divider uses on each cycle of a fractional-N synthesizer. It runs on the divided feedback clock. On every cycle it adds a programmable fractional step K to a phase register whose modulus F is a power of two. When the sum reaches F it emits a carry, and the carry raises the divide value from the integer ratio I to I+1 for that one cycle. Over F cycles the loop therefore divides by I + K/F on average. With a comparison frequency fr/R this gives an output frequency step of fr/(R·F).

The step K and the integer ratio I are sampled only on the clock edge, so a new setting never changes the ratio partway through a feedback period. A setting change leaves the accumulated phase as it is. Noise shaping beyond first order, the reference divider and all analog loop parts lie outside this block.

Top module: `frac_ratio_acc`

## Requirements
- R1: F equals 2^FRAC_W and the phase register is FRAC_W bits wide. A synchronous, active-high `rst` clears the phase, `carry` and `div_ratio` to 0.
- R2: On each rising edge after reset, the effective step is added to the phase. `carry` is registered as 1 when the sum is F or more, and the phase wraps modulo F. Starting from reset with a constant step K, `carry` after the n-th edge equals floor(nK/F) − floor((n−1)K/F).
- R3: `div_ratio` is registered on the same edge as `carry` and equals the `int_n` sampled at that edge plus `carry`. It is INT_W+1 bits wide, so when I is at its maximum, I+1 does not wrap.
- R4: While K is held constant, any F consecutive cycles contain exactly K carries.
- R5: With K equal to F, `carry` is 1 on every cycle and `div_ratio` is always I+1.
- R6: A `frac_k` value above F is saturated to F.
- R7: With K equal to 0, `carry` stays 0 and `div_ratio` equals I.
- R8: A change of `frac_k` takes effect at the next edge and keeps the accumulated phase. From reset, steps of 200, 100, 212 and then 1 with F=256 give carries on the second and third edges only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divided feedback clock |
| rst | input | 1 | Synchronous active-high reset |
| frac_k | input | FRAC_W+1 | Fractional step K, valid range 0..F |
| int_n | input | INT_W | Integer division ratio I |
| carry | output | 1 | Registered overflow of the phase sum |
| div_ratio | output | INT_W+1 | Divide value for the current feedback period, I or I+1 |

## Verification
A first group of runs starts from reset with a range of steps: the smallest non-zero step, an odd step, steps of a quarter and a half of F, F−1 and F. Each run compares the whole carry sequence against the closed-form floor expression, so a wrong wrap point, an off-by-one compare or a lost remainder shows up in a distinct cycle. The same runs also count the carries over F cycles. An integer ratio at its maximum exposes a truncated divide word. A step above F separates saturation from plain truncation. A step of zero checks the no-carry case. A mid-stream step sequence shows whether the phase is kept when K changes or reloaded.

// File: rtl/frac_ratio_acc.sv
module frac_ratio_acc #(
  parameter int FRAC_W = 8,
  parameter int INT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FRAC_W:0]   frac_k,
  input  logic [INT_W-1:0]  int_n,
  output logic              carry,
  output logic [INT_W:0]    div_ratio
);
  localparam int unsigned    MODULUS = 1 << FRAC_W;
  localparam logic [FRAC_W:0] K_MAX  = (FRAC_W+1)'(MODULUS);

  logic [FRAC_W-1:0] phase;
  logic [FRAC_W:0]   k_eff;
  logic [FRAC_W:0]   sum;

  assign k_eff = (frac_k > K_MAX) ? K_MAX : frac_k;
  assign sum   = {1'b0, phase} + k_eff;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= '0;
      carry     <= 1'b0;
      div_ratio <= '0;
    end else begin
      phase     <= sum[FRAC_W-1:0];
      carry     <= sum[FRAC_W];
      div_ratio <= {1'b0, int_n} + (INT_W+1)'(sum[FRAC_W]);
    end
  end
endmodule

module frac_ratio_acc_chk #(
  parameter int FRAC_W = 8,
  parameter int INT_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [FRAC_W:0]   frac_k,
  input logic [INT_W-1:0]  int_n,
  input logic              carry,
  input logic [INT_W:0]    div_ratio
);
  localparam logic [FRAC_W:0] K_MAX = (FRAC_W+1)'(1 << FRAC_W);
  logic up = 1'b0;
  always_ff @(posedge clk) if (rst) up <= 1'b1;

  a_r1_reset_clears: assert property (@(posedge clk)
    (up && $past(rst)) |-> (!carry && div_ratio == '0));

  a_r3_div_follows_carry: assert property (@(posedge clk) disable iff (rst)
    (up && !$past(rst)) |-> (div_ratio == {1'b0, $past(int_n)} + (INT_W+1)'(carry)));

  a_r5_full_step_carries: assert property (@(posedge clk) disable iff (rst)
    (up && !$past(rst) && $past(frac_k) >= K_MAX) |-> carry);

  a_r7_zero_step_quiet: assert property (@(posedge clk) disable iff (rst)
    (up && !$past(rst) && $past(frac_k) == '0) |-> !carry);
endmodule

bind frac_ratio_acc frac_ratio_acc_chk #(.FRAC_W(FRAC_W), .INT_W(INT_W)) u_chk (.*);

// File: tb/frac_ratio_acc_tb.sv
module frac_ratio_acc_tb;
  localparam int FRAC_W = 8;
  localparam int INT_W  = 8;
  localparam int F      = 1 << FRAC_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [FRAC_W:0]   frac_k = '0;
  logic [INT_W-1:0]  int_n = '0;
  logic              carry;
  logic [INT_W:0]    div_ratio;

  int errors = 0;
  int checks = 0;

  frac_ratio_acc #(.FRAC_W(FRAC_W), .INT_W(INT_W)) u_dut (.*);

  always #4 clk = ~clk;

  localparam int NV = 6;
  localparam int VEC [NV][2] = '{
    '{1, 10}, '{3, 20}, '{64, 5}, '{128, 100}, '{255, 7}, '{256, 255}
  };

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step();
    rst = 1'b0;
    check(carry == 1'b0 && div_ratio == '0, "R1 reset", longint'(div_ratio), 0);
  endtask

  // keff is the step after saturation (R6); expected carry from the R2 formula
  task automatic run_k(input int k_in, input int keff, input int i_in, input string tag);
    int cnt = 0;
    int bad = 0;
    longint bad_act = 0;
    longint bad_exp = 0;
    do_reset();
    frac_k = (FRAC_W+1)'(k_in);
    int_n  = INT_W'(i_in);
    for (int n = 1; n <= F; n++) begin
      longint exp_c;
      step();
      exp_c = (longint'(n) * keff) / F - (longint'(n - 1) * keff) / F;
      if (carry) cnt++;
      if (longint'(carry) != exp_c || longint'(div_ratio) != i_in + exp_c) begin
        if (bad == 0) begin
          bad_act = longint'(div_ratio);
          bad_exp = i_in + exp_c;
        end
        bad++;
      end
    end
    check(bad == 0, {tag, " R2/R3 sequence"}, bad_act, bad_exp);
    check(cnt == keff, {tag, " R4 carry count"}, cnt, keff);
  endtask

  initial begin
    int seq_c [4];
    int steps [4];
    int seen;
    for (int v = 0; v < NV; v++)
      run_k(VEC[v][0], VEC[v][0], VEC[v][1], $sformatf("K=%0d", VEC[v][0]));

    // R5: full step with I at max gives I+1 = 256 on every cycle
    run_k(F, F, 255, "R5 full");
    // R6: saturation of K above F
    run_k(F + 44, F, 3, "R6 sat");
    // R7: zero step
    run_k(0, 0, 42, "R7 zero");

    // R8: step changes keep the phase
    do_reset();
    int_n = 8'd9;
    steps = '{200, 100, 212, 1};
    seq_c = '{0, 1, 1, 0};
    seen = 0;
    for (int s = 0; s < 4; s++) begin
      frac_k = (FRAC_W+1)'(steps[s]);
      step();
      if (int'(carry) != seq_c[s] || int'(div_ratio) != 9 + seq_c[s]) seen++;
      check(int'(carry) == seq_c[s], $sformatf("R8 edge %0d", s + 1), carry, seq_c[s]);
    end
    check(seen == 0, "R8 div values", seen, 0);

    // R1: reset mid-run with K=1 restarts phase: first carry exactly on edge F
    do_reset();
    frac_k = 9'd1;
    begin
      int first = 0;
      for (int n = 1; n <= F; n++) begin
        step();
        if (carry && first == 0) first = n;
      end
      check(first == F, "R1 phase cleared", first, F);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule